// File: doc/BRIEF.md
# Packed-Word Raster Timing Generator

This block produces the sync, blanking and pixel-position signals for a progressive raster display. It runs on the pixel clock. It takes its timing from two 32-bit configuration words, one for the horizontal axis and one for the vertical axis, and from a two-bit scan control register. Software writes all of these over a single-cycle write bus. Horizontal lengths are stored in units of four pixels, and vertical lengths are stored in whole lines. A status flag goes high at the start of vertical retrace. Software polls this flag and clears it by writing a one to it.

Each axis is a four-state machine. The states are PH_ACTIVE, PH_FRONT, PH_SYNC and PH_BACK. The machine moves PH_ACTIVE→PH_FRONT→PH_SYNC→PH_BACK→PH_ACTIVE, and each transition happens on the last count of the current state. The horizontal machine advances on every clock. The vertical machine advances only on the clock that ends a line. While scan-out is disabled, both machines are forced to PH_ACTIVE with a count of zero.

The length fields are copied into shadow registers. These copies are taken continuously while scan-out is disabled, and once per frame while it runs. A rewritten word therefore never tears the frame that is already on screen. Each timing word also has a polarity bit and a sync-suppress bit, and both act at once. Together they support the power-saving modes that turn one sync or both syncs off.

Top module: `vtg_top`

## Requirements
- R1: After reset, hsync=1, vsync=1, blank=1, active=0, pix_x=0, pix_y=0 and vretrace=0. Every register is zero, so scan-out is disabled and both syncs are active low.
- R2: The horizontal word is written at bus address 0. Its fields are:
  - bits [8:0]: active width low bits
  - bits [13:9]: front porch
  - bits [20:14]: sync width
  - bits [27:21]: back porch

  Each field counts units of 4 pixels, and a zero field counts as one unit. A line runs through active, front porch, sync and back porch, in that order. Its length is 4 × (sum of the units) clocks, and hsync is asserted only in the sync part.
- R3: Bits [29:28] of the horizontal word are bits [10:9] of the active width. This lets the active width reach 2047 units.
- R4: The vertical word is written at bus address 1. Its fields are:
  - bits [10:0]: active lines
  - bits [15:11]: front porch
  - bits [21:16]: sync lines
  - bits [27:22]: back porch

  All fields are in whole lines, and a zero field counts as one line. A frame runs through the four parts in the same order as a line, and vsync is asserted for the whole sync lines.
- R5: Bit 31 of each timing word sets the polarity of its sync output: 1 means active high and 0 means active low. A sync output that is not asserted sits at the inverse of the polarity bit.
- R6: When bit 30 of a timing word is 1, that word's sync output stays at its inactive level. Bits 30 and 31 take effect on the clock after the write.
- R7: The scan control register is at bus address 2. Bit 0 enables scan-out and bit 1 forces blanking. With both bits set, blank=1 and active=0, while the syncs keep running.
- R8: When the enable bit is 0, the counters are held at the first active pixel, blank=1, active=0, both syncs are inactive and pix_x=pix_y=0. Once enabled, the first clock shows pixel (0,0).
- R9: vretrace goes to 1 on the first clock of the first vertical sync line. Writing a 1 to bit 0 at bus address 3 clears it. Writing a 0 there has no effect.
- R10: Length fields written while scan-out runs take effect at the first clock of the next frame. Length fields written while scan-out is disabled take effect as soon as it is enabled.
- R11: In the active area, pix_x and pix_y give the pixel column and line, counted from 0. Outside the active area of its axis, each of them reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 2 | Register select: 0 horizontal, 1 vertical, 2 control, 3 status |
| bus_wdata | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync, polarity set by the word |
| vsync | output | 1 | Vertical sync, polarity set by the word |
| blank | output | 1 | High when no pixel is shown |
| active | output | 1 | High on visible pixels |
| pix_x | output | 13 | Column inside the active area |
| pix_y | output | 11 | Line inside the active area |
| vretrace | output | 1 | Vertical retrace status flag |

## Verification
The assertions check the following on every cycle:
- pix_x steps by exactly one across consecutive visible pixels.
- A suppressed hsync sits at its inactive level.
- active never coincides with blank or with disabled scan-out.
- The retrace flag only rises inside vertical sync.
- A clear write that does not collide with a set drops the flag.

Some behaviour can only be shown by the bench scenarios, which replay full frames against an independent position counter:
- the exact lengths and ordering of porches and sync pulses
- the use of the high active-width bits
- the deferral of new lengths to the frame boundary
- the effect of the blanking and enable bits

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int WORD_W = 32;
    localparam int HU_W   = 11;          // horizontal active width in 4-pixel units
    localparam int HPX_W  = HU_W + 2;    // horizontal count in pixels
    localparam int VLN_W  = 11;          // vertical count in lines

    localparam logic [1:0] A_HWORD = 2'd0;
    localparam logic [1:0] A_VWORD = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;
    localparam logic [1:0] A_STAT  = 2'd3;

    localparam int BIT_OFF = 30;
    localparam int BIT_POL = 31;

    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_FRONT,
        PH_SYNC,
        PH_BACK
    } phase_e;

    function automatic logic [HU_W-1:0] h_act_units(input logic [WORD_W-1:0] w);
        return {w[29:28], w[8:0]};
    endfunction

    function automatic logic [4:0] h_fp_units(input logic [WORD_W-1:0] w);
        return w[13:9];
    endfunction

    function automatic logic [6:0] h_sync_units(input logic [WORD_W-1:0] w);
        return w[20:14];
    endfunction

    function automatic logic [6:0] h_bp_units(input logic [WORD_W-1:0] w);
        return w[27:21];
    endfunction

    function automatic logic [10:0] v_act_lines(input logic [WORD_W-1:0] w);
        return w[10:0];
    endfunction

    function automatic logic [4:0] v_fp_lines(input logic [WORD_W-1:0] w);
        return w[15:11];
    endfunction

    function automatic logic [5:0] v_sync_lines(input logic [WORD_W-1:0] w);
        return w[21:16];
    endfunction

    function automatic logic [5:0] v_bp_lines(input logic [WORD_W-1:0] w);
        return w[27:22];
    endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              retrace_set,
    output logic [WORD_W-1:0] hword,
    output logic [WORD_W-1:0] vword,
    output logic              vid_en,
    output logic              vid_blank,
    output logic              vretrace,
    output logic              stat_clr
);

    always_comb begin
        stat_clr = wr_en && (addr == A_STAT) && wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hword     <= '0;
            vword     <= '0;
            vid_en    <= 1'b0;
            vid_blank <= 1'b0;
            vretrace  <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    A_HWORD: hword <= wdata;
                    A_VWORD: vword <= wdata;
                    A_CTRL: begin
                        vid_en    <= wdata[0];
                        vid_blank <= wdata[1];
                    end
                    A_STAT: ;
                endcase
            end
            // a set in the same cycle as a clear wins
            vretrace <= retrace_set | (vretrace & ~stat_clr);
        end
    end

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] len_act,
    input  logic [CNT_W-1:0] len_fp,
    input  logic [CNT_W-1:0] len_sync,
    input  logic [CNT_W-1:0] len_bp,
    output logic [CNT_W-1:0] pos,
    output logic             in_active,
    output logic             in_sync,
    output logic             wrap,
    output logic             sync_enter
);

    phase_e           st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cur_len;
    logic             last;

    // next-state logic
    always_comb begin
        unique case (st_q)
            PH_ACTIVE: cur_len = len_act;
            PH_FRONT:  cur_len = len_fp;
            PH_SYNC:   cur_len = len_sync;
            PH_BACK:   cur_len = len_bp;
        endcase
        last  = (cnt_q == cur_len - 1'b1);
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!run) begin
            st_d  = PH_ACTIVE;
            cnt_d = '0;
        end else if (step) begin
            if (last) begin
                cnt_d = '0;
                unique case (st_q)
                    PH_ACTIVE: st_d = PH_FRONT;
                    PH_FRONT:  st_d = PH_SYNC;
                    PH_SYNC:   st_d = PH_BACK;
                    PH_BACK:   st_d = PH_ACTIVE;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_ACTIVE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        in_active  = (st_q == PH_ACTIVE);
        in_sync    = (st_q == PH_SYNC);
        pos        = in_active ? cnt_q : '0;
        wrap       = run && step && last && (st_q == PH_BACK);
        sync_enter = run && step && last && (st_q == PH_FRONT);
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              active,
    output logic [HPX_W-1:0]  pix_x,
    output logic [VLN_W-1:0]  pix_y,
    output logic              vretrace
);

    logic [WORD_W-1:0] hword, vword;
    logic              vid_en, vid_blank, stat_clr, retrace_set;

    logic [HPX_W-1:0]  lh_act, lh_fp, lh_sync, lh_bp;
    logic [HPX_W-1:0]  sh_act, sh_fp, sh_sync, sh_bp;
    logic [VLN_W-1:0]  lv_act, lv_fp, lv_sync, lv_bp;
    logic [VLN_W-1:0]  sv_act, sv_fp, sv_sync, sv_bp;

    logic h_in_active, h_in_sync, h_wrap, h_sync_enter;
    logic v_in_active, v_in_sync, v_wrap;
    logic unused_vbits;

    function automatic logic [HU_W-1:0] nz_h(input logic [HU_W-1:0] u);
        return (u == '0) ? HU_W'(1) : u;
    endfunction

    function automatic logic [VLN_W-1:0] nz_v(input logic [VLN_W-1:0] u);
        return (u == '0) ? VLN_W'(1) : u;
    endfunction

    vtg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .retrace_set (retrace_set),
        .hword       (hword),
        .vword       (vword),
        .vid_en      (vid_en),
        .vid_blank   (vid_blank),
        .vretrace    (vretrace),
        .stat_clr    (stat_clr)
    );

    // decode the live words into pixel and line lengths
    always_comb begin
        lh_act  = {nz_h(h_act_units(hword)), 2'b00};
        lh_fp   = {nz_h(HU_W'(h_fp_units(hword))), 2'b00};
        lh_sync = {nz_h(HU_W'(h_sync_units(hword))), 2'b00};
        lh_bp   = {nz_h(HU_W'(h_bp_units(hword))), 2'b00};
        lv_act  = nz_v(v_act_lines(vword));
        lv_fp   = nz_v(VLN_W'(v_fp_lines(vword)));
        lv_sync = nz_v(VLN_W'(v_sync_lines(vword)));
        lv_bp   = nz_v(VLN_W'(v_bp_lines(vword)));
    end

    assign unused_vbits = ^vword[29:28];

    // shadow lengths: follow the live words while idle, reload at frame end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_act  <= HPX_W'(4);
            sh_fp   <= HPX_W'(4);
            sh_sync <= HPX_W'(4);
            sh_bp   <= HPX_W'(4);
            sv_act  <= VLN_W'(1);
            sv_fp   <= VLN_W'(1);
            sv_sync <= VLN_W'(1);
            sv_bp   <= VLN_W'(1);
        end else if (!vid_en || v_wrap) begin
            sh_act  <= lh_act;
            sh_fp   <= lh_fp;
            sh_sync <= lh_sync;
            sh_bp   <= lh_bp;
            sv_act  <= lv_act;
            sv_fp   <= lv_fp;
            sv_sync <= lv_sync;
            sv_bp   <= lv_bp;
        end
    end

    vtg_axis #(.CNT_W(HPX_W)) u_hax (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (vid_en),
        .step       (1'b1),
        .len_act    (sh_act),
        .len_fp     (sh_fp),
        .len_sync   (sh_sync),
        .len_bp     (sh_bp),
        .pos        (pix_x),
        .in_active  (h_in_active),
        .in_sync    (h_in_sync),
        .wrap       (h_wrap),
        .sync_enter (h_sync_enter)
    );

    vtg_axis #(.CNT_W(VLN_W)) u_vax (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (vid_en),
        .step       (h_wrap),
        .len_act    (sv_act),
        .len_fp     (sv_fp),
        .len_sync   (sv_sync),
        .len_bp     (sv_bp),
        .pos        (pix_y),
        .in_active  (v_in_active),
        .in_sync    (v_in_sync),
        .wrap       (v_wrap),
        .sync_enter (retrace_set)
    );

    always_comb begin
        hsync  = (vid_en && h_in_sync && !hword[BIT_OFF]) ? hword[BIT_POL] : ~hword[BIT_POL];
        vsync  = (vid_en && v_in_sync && !vword[BIT_OFF]) ? vword[BIT_POL] : ~vword[BIT_POL];
        blank  = !vid_en || vid_blank || !(h_in_active && v_in_active);
        active = !blank;
    end

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             vid_en,
    input logic             blank,
    input logic             active,
    input logic [HPX_W-1:0] pix_x,
    input logic             hsync,
    input logic             h_off,
    input logic             h_pol,
    input logic             vretrace,
    input logic             v_in_sync,
    input logic             stat_clr,
    input logic             retrace_set
);

    a_r11_x_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (pix_x == $past(pix_x) + HPX_W'(1)));

    a_r7_active_excl: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (!blank && vid_en));

    a_r8_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |=> (pix_x == '0));

    a_r6_hsync_off: assert property (@(posedge clk) disable iff (!rst_n)
        h_off |-> (hsync == !h_pol));

    a_r9_rise_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vretrace) |-> v_in_sync);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_clr) && !$past(retrace_set)) |-> !vretrace);

endmodule

bind vtg_top vtg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vid_en      (vid_en),
    .blank       (blank),
    .active      (active),
    .pix_x       (pix_x),
    .hsync       (hsync),
    .h_off       (hword[30]),
    .h_pol       (hword[31]),
    .vretrace    (vretrace),
    .v_in_sync   (v_in_sync),
    .stat_clr    (stat_clr),
    .retrace_set (retrace_set)
);

// File: tb/sim_vtg_top.sv
module sim_vtg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        hsync, vsync, blank, active, vretrace;
    logic [12:0] pix_x;
    logic [10:0] pix_y;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_lh = 0, m_lv = 0, m_sh = 0, m_sv = 0;
    bit m_en = 0, m_blk = 0, m_flag = 0;
    int m_hp = 0, m_vl = 0;

    always #5 clk = ~clk;

    vtg_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .hsync(hsync), .vsync(vsync), .blank(blank),
        .active(active), .pix_x(pix_x), .pix_y(pix_y), .vretrace(vretrace)
    );

    function automatic int one_min(input int f);
        return (f == 0) ? 1 : f;
    endfunction

    function automatic int ha(input logic [31:0] w); return 4 * one_min(int'({w[29:28], w[8:0]})); endfunction
    function automatic int hf(input logic [31:0] w); return 4 * one_min(int'(w[13:9])); endfunction
    function automatic int hs(input logic [31:0] w); return 4 * one_min(int'(w[20:14])); endfunction
    function automatic int hb(input logic [31:0] w); return 4 * one_min(int'(w[27:21])); endfunction
    function automatic int va(input logic [31:0] w); return one_min(int'(w[10:0])); endfunction
    function automatic int vf(input logic [31:0] w); return one_min(int'(w[15:11])); endfunction
    function automatic int vs(input logic [31:0] w); return one_min(int'(w[21:16])); endfunction
    function automatic int vb(input logic [31:0] w); return one_min(int'(w[27:22])); endfunction
    function automatic int htot(input logic [31:0] w); return ha(w) + hf(w) + hs(w) + hb(w); endfunction
    function automatic int vtot(input logic [31:0] w); return va(w) + vf(w) + vs(w) + vb(w); endfunction

    function automatic logic [31:0] hw(input int a, input int f, input int s, input int b,
                                       input bit off, input bit pol);
        logic [10:0] a11 = a[10:0];
        return {pol, off, a11[10:9], b[6:0], s[6:0], f[4:0], a11[8:0]};
    endfunction

    function automatic logic [31:0] vw(input int a, input int f, input int s, input int b,
                                       input bit off, input bit pol);
        return {pol, off, 2'b00, b[5:0], s[5:0], f[4:0], a[10:0]};
    endfunction

    task automatic tick(input bit w, input logic [1:0] a, input logic [31:0] d, input string tag);
        bit hact, vact, hsr, vsr, e_hs, e_vs, e_bl, e_ac, setf;
        int e_x, e_y;
        @(negedge clk);
        hact = m_hp < ha(m_sh);
        vact = m_vl < va(m_sv);
        hsr  = (m_hp >= ha(m_sh) + hf(m_sh)) && (m_hp < ha(m_sh) + hf(m_sh) + hs(m_sh));
        vsr  = (m_vl >= va(m_sv) + vf(m_sv)) && (m_vl < va(m_sv) + vf(m_sv) + vs(m_sv));
        e_hs = (m_en && hsr && !m_lh[30]) ? m_lh[31] : !m_lh[31];
        e_vs = (m_en && vsr && !m_lv[30]) ? m_lv[31] : !m_lv[31];
        e_bl = !m_en || m_blk || !(hact && vact);
        e_ac = !e_bl;
        e_x  = hact ? m_hp : 0;
        e_y  = vact ? m_vl : 0;
        checks++;
        if (hsync !== e_hs || vsync !== e_vs || blank !== e_bl || active !== e_ac ||
            int'(pix_x) != e_x || int'(pix_y) != e_y || vretrace !== m_flag) begin
            errors++;
            $display("FAIL %s: got hs=%b vs=%b bl=%b ac=%b x=%0d y=%0d rt=%b, expected hs=%b vs=%b bl=%b ac=%b x=%0d y=%0d rt=%b",
                     tag, hsync, vsync, blank, active, pix_x, pix_y, vretrace,
                     e_hs, e_vs, e_bl, e_ac, e_x, e_y, m_flag);
        end
        bus_wr    = w;
        bus_addr  = a;
        bus_wdata = d;
        // model advance across the coming edge
        setf = 0;
        if (!m_en) begin
            m_hp = 0; m_vl = 0; m_sh = m_lh; m_sv = m_lv;
        end else begin
            m_hp++;
            if (m_hp == htot(m_sh)) begin
                m_hp = 0;
                m_vl++;
                if (m_vl == vtot(m_sv)) begin
                    m_vl = 0; m_sh = m_lh; m_sv = m_lv;
                end
            end
            setf = (m_hp == 0) && (m_vl == va(m_sv) + vf(m_sv));
        end
        if (setf) m_flag = 1;
        else if (w && a == 2'd3 && d[0]) m_flag = 0;
        if (w) begin
            case (a)
                2'd0: m_lh = d;
                2'd1: m_lv = d;
                2'd2: begin m_en = d[0]; m_blk = d[1]; end
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 32'd0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        tick(1'b1, a, d, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R1 reset state");

        // fixed mode, vsync active high
        wr(2'd0, hw(4, 1, 2, 1, 0, 0), "R2");
        wr(2'd1, vw(6, 1, 2, 2, 0, 1), "R4");
        wr(2'd2, 32'd1, "R8 enable");
        idle(720, "R2 R4 R5 R11 R9");

        // forced blanking with scan running
        wr(2'd2, 32'd3, "R7");
        idle(100, "R7 blank forced");
        wr(2'd2, 32'd1, "R7");

        // sync suppression on both axes, immediate
        wr(2'd0, hw(4, 1, 2, 1, 1, 1), "R6");
        wr(2'd1, vw(6, 1, 2, 2, 1, 0), "R6");
        idle(400, "R6 sync off");
        wr(2'd0, hw(4, 1, 2, 1, 0, 1), "R5");
        wr(2'd1, vw(6, 1, 2, 2, 0, 0), "R5");
        idle(400, "R5 R9");

        // status clear: write of 0 ignored, write of 1 clears
        wr(2'd3, 32'd0, "R9 zero write ignored");
        idle(3, "R9");
        wr(2'd3, 32'd1, "R9 clear");
        idle(20, "R9 cleared");

        // length change mid-frame waits for frame boundary
        idle(37, "R10");
        wr(2'd0, hw(2, 0, 1, 3, 0, 1), "R10");
        idle(900, "R10 deferred lengths");

        // disable holds counters at origin
        wr(2'd2, 32'd0, "R8");
        idle(50, "R8 disabled");

        // random modes
        for (int k = 0; k < 8; k++) begin
            logic [31:0] h, v;
            h = hw($urandom_range(8, 0), $urandom_range(3, 0), $urandom_range(4, 0),
                   $urandom_range(3, 0), 1'b0, 1'($urandom_range(1, 0)));
            v = vw($urandom_range(6, 0), $urandom_range(2, 0), $urandom_range(3, 0),
                   $urandom_range(2, 0), 1'b0, 1'($urandom_range(1, 0)));
            wr(2'd0, h, "R10 idle load");
            wr(2'd1, v, "R10 idle load");
            wr(2'd2, 32'd1, "R8");
            idle(htot(h) * vtot(v) * 2 + 5, "R2 R4 R5 R11");
            wr(2'd2, 32'd0, "R8");
        end

        // wide line using high active-width bits: 520 units
        wr(2'd0, hw(520, 1, 1, 1, 0, 0), "R3");
        wr(2'd1, vw(1, 1, 1, 1, 0, 0), "R3");
        wr(2'd2, 32'd1, "R3");
        idle(8400, "R3 wide active");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule